// File: doc/BRIEF.md
# Coarse Timestamp Unit

This block keeps a single free-running 56-bit base timestamp. The base advances by one on every cycle in which a reference-tick enable is high. The enable comes from a 19.2 MHz reference clock and is brought into the block's clock domain outside it. From the base the block derives three coarser 32-bit timestamps, one for each consumer:

- a logging stamp;
- a tagging stamp;
- an address-translation stamp.

Each coarse stamp is the base shifted right by its own programmable amount, with the upper bits dropped. A shift of 14 gives roughly 853 µs per coarse step. A shift of 24 gives roughly 874 ms per step.

A single-cycle write port loads one configuration word. That word holds the three shift amounts and a source-select bit for the logging stamp. When the select bit is clear, the logging stamp shows a legacy millisecond count instead of the shifted base. That count has its own prescaler, which divides the reference ticks by 19200. A load port lets the base be preset to any value, for example to align it with another counter.

Top module: `coarse_stamp_unit`

## Requirements
- R1: A synchronous reset clears the base, the millisecond count, its prescaler and the configuration. After reset, every output reads zero.
- R2: The base output increments by exactly one on each clock edge where `ref_tick` is high. It holds its value on edges where `ref_tick` is low.
- R3: The base wraps from 2^56-1 to 0 on a tick.
- R4: A high `ts_load` sets the base to `ts_load_val` at that edge, and the load takes priority over a tick in the same cycle. A load does not change the millisecond count.
- R5: `tag_ts` equals bits 31:0 of (base >> S), where S is configuration bits 12:8. The value is computed from the base and configuration as they stood one edge earlier.
- R6: `xlat_ts` follows the same rule as R5, with S taken from configuration bits 20:16.
- R7: When configuration bit 7 is 1, `log_ts` follows the same rule as R5, with S taken from configuration bits 4:0.
- R8: When configuration bit 7 is 0, `log_ts` shows the millisecond count, one edge late.
- R9: The millisecond count rises by exactly one for every 19200 reference ticks, counted from reset. Counting is continuous, so ticks carry across any gaps in `ref_tick`.
- R10: A high `cfg_wr` captures `cfg_wdata` at that edge, and the stamps use the new fields from the next edge on. A configuration write never changes the base or the millisecond count.
- R11: Configuration bits 31:21, 15:13 and 6:5 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | One-cycle enable per reference-clock tick |
| ts_load | input | 1 | Preset the base this cycle |
| ts_load_val | input | 56 | Value to preset the base to |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration word |
| base_ts | output | 56 | Full-resolution base timestamp |
| log_ts | output | 32 | Logging stamp |
| tag_ts | output | 32 | Tagging stamp |
| xlat_ts | output | 32 | Address-translation stamp |

## Verification
The base is preset just below shift boundaries, such as 2^14-1 and 2^24-1, and then ticked once. A carry into the first kept bit must then show up in the coarse stamp, which separates an off-by-one shift from a correct one. A patterned 56-bit value read with shifts 0, 14, 24 and 31 separates the three shift fields from one another. It also confirms that high bits are truncated rather than saturated. Runs of exactly 19199 and 19200 ticks, with a configuration write part way through, pin down the millisecond divider and show that writes leave both counters alone. A preset to all ones followed by one tick exercises the 56-bit wrap.

// File: rtl/cstamp_pkg.sv
package cstamp_pkg;
  localparam int BASE_W = 56;
  localparam int VIEW_W = 32;
  localparam int SH_W   = 5;
  localparam int CFG_W  = 32;
  localparam int MS_DIV = 19200;

  // Field positions of the configuration word (consumers decode these).
  localparam int LOG_SH_LSB  = 0;
  localparam int LOG_SEL_BIT = 7;
  localparam int TAG_SH_LSB  = 8;
  localparam int XL_SH_LSB   = 16;

  typedef struct packed {
    logic            log_sel;
    logic [SH_W-1:0] log_sh;
    logic [SH_W-1:0] tag_sh;
    logic [SH_W-1:0] xl_sh;
  } cfg_t;

  function automatic cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    cfg_t c;
    c.log_sel = w[LOG_SEL_BIT];
    c.log_sh  = w[LOG_SH_LSB +: SH_W];
    c.tag_sh  = w[TAG_SH_LSB +: SH_W];
    c.xl_sh   = w[XL_SH_LSB +: SH_W];
    return c;
  endfunction
endpackage

// File: rtl/cstamp_base_ctr.sv
module cstamp_base_ctr #(
  parameter int W = 56
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (tick) cnt <= cnt + ONE;
  end
endmodule

// File: rtl/cstamp_ms_ctr.sv
module cstamp_ms_ctr #(
  parameter int DIV = 19200,
  parameter int W   = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  output logic [W-1:0] ms
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(DIV - 1);

  logic [PW-1:0] pre_q;
  logic          wrap;

  assign wrap = tick && (pre_q == PRE_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q <= '0;
      ms    <= '0;
    end else if (tick) begin
      pre_q <= wrap ? '0 : pre_q + PW'(1);
      if (wrap) ms <= ms + W'(1);
    end
  end
endmodule

// File: rtl/cstamp_view.sv
module cstamp_view #(
  parameter int IN_W    = 56,
  parameter int OUT_W   = 32,
  parameter int SH_W    = 5,
  parameter bit HAS_ALT = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  base,
  input  logic [SH_W-1:0]  shift,
  input  logic             use_shift,
  input  logic [OUT_W-1:0] alt_val,
  output logic [OUT_W-1:0] view
);
  logic [IN_W-1:0]  shifted;
  logic [OUT_W-1:0] next_view;

  assign shifted = base >> shift;

  generate
    if (HAS_ALT) begin : g_alt
      assign next_view = use_shift ? shifted[OUT_W-1:0] : alt_val;
    end else begin : g_plain
      logic unused_ok;
      assign unused_ok = use_shift ^ (^alt_val);
      assign next_view = shifted[OUT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) view <= '0;
    else     view <= next_view;
  end
endmodule

// File: rtl/coarse_stamp_unit.sv
module coarse_stamp_unit
  import cstamp_pkg::*;
#(
  parameter int BW  = BASE_W,
  parameter int VW  = VIEW_W,
  parameter int DIV = MS_DIV
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_tick,
  input  logic             ts_load,
  input  logic [BW-1:0]    ts_load_val,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [BW-1:0]    base_ts,
  output logic [VW-1:0]    log_ts,
  output logic [VW-1:0]    tag_ts,
  output logic [VW-1:0]    xlat_ts
);
  localparam int NV = 3;

  cfg_t          cfg_q;
  logic [VW-1:0] ms_q;
  logic [SH_W-1:0] sh_arr  [NV];
  logic [VW-1:0]   view_arr[NV];

  always_ff @(posedge clk) begin
    if (rst)         cfg_q <= '0;
    else if (cfg_wr) cfg_q <= decode_cfg(cfg_wdata);
  end

  cstamp_base_ctr #(.W(BW)) u_base (
    .clk(clk), .rst(rst), .tick(ref_tick),
    .load(ts_load), .load_val(ts_load_val), .cnt(base_ts)
  );

  cstamp_ms_ctr #(.DIV(DIV), .W(VW)) u_ms (
    .clk(clk), .rst(rst), .tick(ref_tick), .ms(ms_q)
  );

  assign sh_arr[0] = cfg_q.log_sh;
  assign sh_arr[1] = cfg_q.tag_sh;
  assign sh_arr[2] = cfg_q.xl_sh;

  for (genvar g = 0; g < NV; g++) begin : g_view
    cstamp_view #(
      .IN_W(BW), .OUT_W(VW), .SH_W(SH_W), .HAS_ALT(g == 0)
    ) u_view (
      .clk(clk), .rst(rst), .base(base_ts), .shift(sh_arr[g]),
      .use_shift(cfg_q.log_sel), .alt_val(ms_q), .view(view_arr[g])
    );
  end

  assign log_ts  = view_arr[0];
  assign tag_ts  = view_arr[1];
  assign xlat_ts = view_arr[2];
endmodule

// File: rtl/cstamp_chk.sv
module cstamp_chk
  import cstamp_pkg::*;
#(
  parameter int BW = BASE_W,
  parameter int VW = VIEW_W
) (
  input logic             clk,
  input logic             rst,
  input logic             ref_tick,
  input logic             ts_load,
  input logic [BW-1:0]    ts_load_val,
  input logic             cfg_wr,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic [BW-1:0]    base_ts,
  input logic [VW-1:0]    log_ts,
  input logic [VW-1:0]    tag_ts,
  input logic [VW-1:0]    xlat_ts,
  input cfg_t             cfg_q,
  input logic [VW-1:0]    ms_q
);
  function automatic logic [VW-1:0] shr(input logic [BW-1:0] b, input logic [SH_W-1:0] s);
    logic [BW-1:0] t;
    t = b >> s;
    return t[VW-1:0];
  endfunction

  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (base_ts == '0 && ms_q == '0 && cfg_q == '0)); // R1
  AST_BASE_STEP: assert property (@(posedge clk) disable iff (rst)
    (ref_tick && !ts_load) |=> base_ts == $past(base_ts) + BW'(1)); // R2
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!ref_tick && !ts_load) |=> $stable(base_ts)); // R2
  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    ts_load |=> base_ts == $past(ts_load_val)); // R4
  AST_TAG_VIEW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> tag_ts == shr($past(base_ts), $past(cfg_q.tag_sh))); // R5
  AST_XLAT_VIEW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> xlat_ts == shr($past(base_ts), $past(cfg_q.xl_sh))); // R6
  AST_LOG_SHIFT: assert property (@(posedge clk) disable iff (rst)
    cfg_q.log_sel |=> log_ts == shr($past(base_ts), $past(cfg_q.log_sh))); // R7
  AST_LOG_LEGACY: assert property (@(posedge clk) disable iff (rst)
    !cfg_q.log_sel |=> log_ts == $past(ms_q)); // R8
  AST_MS_STEP: assert property (@(posedge clk) disable iff (rst)
    !$stable(ms_q) |-> ms_q == $past(ms_q) + VW'(1)); // R9
  AST_MS_NEEDS_TICK: assert property (@(posedge clk) disable iff (rst)
    !ref_tick |=> $stable(ms_q)); // R9
  AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    cfg_wr |=> cfg_q == decode_cfg($past(cfg_wdata))); // R10
endmodule

bind coarse_stamp_unit cstamp_chk #(.BW(BW), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .ref_tick(ref_tick), .ts_load(ts_load),
  .ts_load_val(ts_load_val), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .base_ts(base_ts), .log_ts(log_ts), .tag_ts(tag_ts), .xlat_ts(xlat_ts),
  .cfg_q(cfg_q), .ms_q(ms_q)
);

// File: tb/coarse_stamp_unit_test.sv
module coarse_stamp_unit_test;
  localparam int BW = 56;
  localparam int VW = 32;
  localparam int DIV = 19200;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ref_tick = 1'b0;
  logic          ts_load = 1'b0;
  logic [BW-1:0] ts_load_val = '0;
  logic          cfg_wr = 1'b0;
  logic [31:0]   cfg_wdata = '0;
  logic [BW-1:0] base_ts;
  logic [VW-1:0] log_ts, tag_ts, xlat_ts;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  coarse_stamp_unit uut (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .ts_load(ts_load),
    .ts_load_val(ts_load_val), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .base_ts(base_ts), .log_ts(log_ts), .tag_ts(tag_ts), .xlat_ts(xlat_ts)
  );

  // Reference model state
  logic [BW-1:0] m_base = '0;
  longint        m_pre = 0;
  longint        m_ms = 0;
  logic          m_sel = 1'b0;
  logic [4:0]    m_lsh = '0, m_tsh = '0, m_xsh = '0;

  typedef struct {
    int          id;
    logic [63:0] exp;
    string       req;
  } item_t;
  item_t sb_q[$];

  function automatic logic [VW-1:0] ref_shr(input logic [BW-1:0] b, input logic [4:0] s);
    logic [BW-1:0] t;
    t = b >> s;
    return t[VW-1:0];
  endfunction

  // Monitor: pops expected items and compares against the outputs.
  initial begin
    forever begin
      item_t it;
      logic [63:0] act;
      wait (sb_q.size() > 0);
      it = sb_q.pop_front();
      case (it.id)
        0: act = 64'(base_ts);
        1: act = 64'(log_ts);
        2: act = 64'(tag_ts);
        default: act = 64'(xlat_ts);
      endcase
      n_run++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s out%0d actual=%h expected=%h", it.req, it.id, act, it.exp);
      end
    end
  end

  task automatic push(input int id, input logic [63:0] e, input string r);
    item_t it;
    it.id = id; it.exp = e; it.req = r;
    sb_q.push_back(it);
    #0;
    wait (sb_q.size() == 0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle_and_check(input string rb, input string rv);
    idle(2);
    push(0, 64'(m_base), rb);
    push(1, m_sel ? 64'(ref_shr(m_base, m_lsh)) : 64'(m_ms[VW-1:0]), rv);
    push(2, 64'(ref_shr(m_base, m_tsh)), rv);
    push(3, 64'(ref_shr(m_base, m_xsh)), rv);
  endtask

  task automatic ticks(input int n);
    ref_tick = 1'b1;
    idle(n);
    ref_tick = 1'b0;
    m_base = m_base + BW'(n);
    m_pre = m_pre + n;
    m_ms = m_ms + m_pre / DIV;
    m_pre = m_pre % DIV;
  endtask

  task automatic load(input logic [BW-1:0] v);
    ts_load = 1'b1; ts_load_val = v;
    idle(1);
    ts_load = 1'b0;
    m_base = v;
  endtask

  task automatic wr_cfg(input logic [31:0] w);
    cfg_wr = 1'b1; cfg_wdata = w;
    idle(1);
    cfg_wr = 1'b0;
    m_lsh = w[4:0]; m_sel = w[7]; m_tsh = w[12:8]; m_xsh = w[20:16];
  endtask

  function automatic logic [31:0] mk(input bit sel, input int l, input int t, input int x);
    return (32'(x) << 16) | (32'(t) << 8) | (32'(sel) << 7) | 32'(l);
  endfunction

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1: reset state, log shows ms count (zero), shifts zero
    settle_and_check("R1", "R1");

    // R8, R9: legacy ms count; 19199 ticks keep it at zero, one more bumps it
    ticks(DIV - 1);
    settle_and_check("R2", "R8");
    ticks(1);
    settle_and_check("R2", "R9");
    // R10: write mid-run does not disturb the prescaler or the base
    ticks(5000);
    wr_cfg(mk(0, 3, 14, 24));
    settle_and_check("R10", "R10");
    ticks(DIV - 5000);
    settle_and_check("R2", "R9");

    // R4: load overrides a simultaneous tick, ms count untouched
    ref_tick = 1'b1;
    load(56'h00AB_CDEF_0123_4567);
    ref_tick = 1'b0;
    settle_and_check("R4", "R8");

    // R5, R6, R7: patterned value with several shifts
    wr_cfg(mk(1, 0, 14, 24));
    settle_and_check("R4", "R7");
    wr_cfg(mk(1, 31, 0, 14));
    settle_and_check("R5", "R6");
    wr_cfg(mk(1, 14, 31, 0));
    settle_and_check("R5", "R7");

    // Boundary: carry into the first kept bit
    wr_cfg(mk(1, 14, 14, 24));
    load(56'h0000_0000_0000_3FFF);
    settle_and_check("R4", "R7");
    ticks(1);
    settle_and_check("R2", "R5");
    load(56'h0000_0000_00FF_FFFF);
    ticks(1);
    settle_and_check("R2", "R6");

    // R3: wrap from all ones
    wr_cfg(mk(1, 0, 31, 24));
    load({BW{1'b1}});
    settle_and_check("R4", "R5");
    ticks(1);
    settle_and_check("R3", "R3");

    // R11: junk in reserved bits is ignored
    load(56'h0012_3456_789A_BCDE);
    wr_cfg(32'hFFE0_E060 | mk(1, 7, 9, 20));
    settle_and_check("R11", "R11");
    wr_cfg(32'hFFE0_E060 | mk(0, 2, 1, 3));
    settle_and_check("R11", "R8");

    // R1: mid-run reset clears everything
    ticks(17);
    rst = 1'b1; idle(2); rst = 1'b0;
    m_base = '0; m_pre = 0; m_ms = 0; m_sel = 0; m_lsh = 0; m_tsh = 0; m_xsh = 0;
    settle_and_check("R1", "R1");

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule